// File: doc/BRIEF.md
# Segment Address Translation Checker

This block turns a segment and offset pair into a 32-bit linear address and decides in the same step whether the access is legal. One shared datapath serves both addressing modes. In the unprotected mode the 16-bit segment value is scaled by sixteen and added to the offset. In the protected mode the cached descriptor fields are used instead: base, 20-bit limit, granularity, segment class (code or data), a read/write permission bit and the descriptor privilege.

A request is presented for one cycle with `req_vld` high. The result appears on the registered outputs on the next clock edge. Each result carries either a valid address flag or a fault flag with a two-bit reason. When several checks fail, only the reason with the highest priority is reported. The block does not load descriptors, handle paging or apply expand-down stack rules.

Top module: `seg_xlate`

## Requirements
- R1: With `prot_mode` low, the result is `lin_addr = seg_value * 16 + offset` modulo 2^32. It is always valid, with `fault_code` 0.
- R2: With `prot_mode` high, `lin_addr = desc_base + offset` modulo 2^32. For example, a base of 0xFFFFFFF0 plus an offset of 0x10 gives 0. The sum is reported even when the access faults.
- R3: With `desc_gran` low, the limit counts bytes. An offset greater than `desc_limit` faults with reason 1 (limit), and an offset equal to the limit passes.
- R4: With `desc_gran` high, the effective limit is `desc_limit * 4096 + 4095`. An offset above it faults with reason 1.
- R5: `acc_kind` 0 (fetch) faults with reason 2 (type) unless `desc_code` is high. A code segment is always executable.
- R6: `acc_kind` 2 (write) faults with reason 2 when the segment is code, or when it is data with `desc_rw` low. `acc_kind` 1 (read) faults with reason 2 on a code segment with `desc_rw` low. `acc_kind` 3 always faults with reason 2.
- R7: A read or write to a data segment faults with reason 3 (privilege) when max(`cur_pl`, `seg_value[1:0]`) is numerically greater than `desc_dpl`. Accesses to code segments skip this check.
- R8: When several checks fail, the reported reason follows the priority limit, then type, then privilege.
- R9: Results appear one cycle after `req_vld`. `addr_ok` and `fault` are never both high, and `fault_code` is 0 exactly when no fault is flagged. A cycle without a request is followed by both flags low. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Translation request this cycle |
| prot_mode | input | 1 | 1 = descriptor-based mode, 0 = segment×16 mode |
| seg_value | input | 16 | Segment value; in protected mode bits 1:0 are the requested privilege |
| desc_base | input | 32 | Cached descriptor base |
| desc_limit | input | 20 | Cached descriptor limit |
| desc_gran | input | 1 | 1 = limit in 4 KB units |
| desc_code | input | 1 | 1 = code segment, 0 = data segment |
| desc_rw | input | 1 | Code: readable; data: writable |
| desc_dpl | input | 2 | Descriptor privilege |
| offset | input | 32 | Offset within the segment |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| cur_pl | input | 2 | Current privilege |
| lin_addr | output | 32 | Linear address of the last request |
| addr_ok | output | 1 | Address valid, no fault |
| fault | output | 1 | Access faulted |
| fault_code | output | 2 | 0 none, 1 limit, 2 type, 3 privilege |

## Verification
The unprotected mode is swept over corner segments and offsets, including all-ones values, so that the scaling and the 32-bit wrap are visible.

The protected rights check is tried on every combination of segment class, permission bit, descriptor privilege, current and requested privilege and access kind. Each combination is run once with the offset inside the limit and once beyond it. This separates the type and privilege reasons from each other, and shows that the limit reason masks both.

Limit boundaries are probed at the limit itself, one above it, zero and all-ones, for both granularities. This tells byte scaling apart from 4 KB scaling and catches an off-by-one in the compare.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_LIMIT = 2'd1,
      FLT_TYPE  = 2'd2,
      FLT_PRIV  = 2'd3
   } fault_e;

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int ADDR_W       = 32,
   parameter int SEG_W        = 16,
   parameter int REAL_SHIFT   = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              prot_mode,
   input  logic [SEG_W-1:0]  seg_value,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   output logic [ADDR_W-1:0] lin
);
   localparam int SCALED_W = SEG_W + REAL_SHIFT;

   if (SCALED_W > ADDR_W) begin : g_bad_width
      $error("seg_addr_gen: scaled segment wider than address");
   end

   logic [ADDR_W-1:0] real_base;
   assign real_base = ADDR_W'(seg_value) << REAL_SHIFT;

   if (SHARED_ADDER) begin : g_shared
      logic [ADDR_W-1:0] operand;
      assign operand = prot_mode ? base : real_base;
      assign lin     = operand + offset;
   end else begin : g_split
      logic [ADDR_W-1:0] sum_real;
      logic [ADDR_W-1:0] sum_prot;
      assign sum_real = real_base + offset;
      assign sum_prot = base + offset;
      assign lin      = prot_mode ? sum_prot : sum_real;
   end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
   parameter int ADDR_W     = 32,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12
) (
   input  logic [LIMIT_W-1:0] limit,
   input  logic               gran,
   input  logic [ADDR_W-1:0]  offset,
   output logic               over
);
   localparam int EFF_W = LIMIT_W + GRAN_SHIFT;

   if (EFF_W > ADDR_W) begin : g_bad_width
      $error("seg_limit_chk: scaled limit wider than address");
   end

   logic [EFF_W-1:0]  eff_narrow;
   logic [ADDR_W-1:0] eff_limit;

   assign eff_narrow = gran ? {limit, {GRAN_SHIFT{1'b1}}}
                            : {{GRAN_SHIFT{1'b0}}, limit};

   if (EFF_W == ADDR_W) begin : g_full
      assign eff_limit = eff_narrow;
   end else begin : g_pad
      assign eff_limit = {{(ADDR_W-EFF_W){1'b0}}, eff_narrow};
   end

   assign over = offset > eff_limit;
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
   import seg_xlate_pkg::*;
#(
   parameter int PL_W = 2
) (
   input  logic            is_code,
   input  logic            rw,
   input  logic [PL_W-1:0] dpl,
   input  logic [PL_W-1:0] cpl,
   input  logic [PL_W-1:0] rpl,
   input  acc_kind_e       kind,
   output logic            type_flt,
   output logic            priv_flt
);
   logic [PL_W-1:0] eff_pl;
   logic            data_acc;

   assign eff_pl   = (cpl > rpl) ? cpl : rpl;
   assign data_acc = !is_code && (kind == ACC_READ || kind == ACC_WRITE);

   always_comb begin
      unique case (kind)
         ACC_FETCH: type_flt = !is_code;
         ACC_READ:  type_flt = is_code && !rw;
         ACC_WRITE: type_flt = is_code || !rw;
         default:   type_flt = 1'b1;
      endcase
   end

   assign priv_flt = data_acc && (eff_pl > dpl);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SEG_W        = 16,
   parameter int LIMIT_W      = 20,
   parameter int GRAN_SHIFT   = 12,
   parameter int REAL_SHIFT   = 4,
   parameter int PL_W         = 2,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic               prot_mode,
   input  logic [SEG_W-1:0]   seg_value,
   input  logic [ADDR_W-1:0]  desc_base,
   input  logic [LIMIT_W-1:0] desc_limit,
   input  logic               desc_gran,
   input  logic               desc_code,
   input  logic               desc_rw,
   input  logic [PL_W-1:0]    desc_dpl,
   input  logic [ADDR_W-1:0]  offset,
   input  logic [1:0]         acc_kind,
   input  logic [PL_W-1:0]    cur_pl,
   output logic [ADDR_W-1:0]  lin_addr,
   output logic               addr_ok,
   output logic               fault,
   output logic [1:0]         fault_code
);
   if (SEG_W < PL_W) begin : g_bad_sel
      $error("seg_xlate: segment value too narrow for privilege field");
   end

   logic [ADDR_W-1:0] lin_c;
   logic              over_c;
   logic              type_c;
   logic              priv_c;
   fault_e            code_c;

   seg_addr_gen #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W), .REAL_SHIFT(REAL_SHIFT),
      .SHARED_ADDER(SHARED_ADDER)
   ) u_addr (
      .prot_mode(prot_mode), .seg_value(seg_value), .base(desc_base),
      .offset(offset), .lin(lin_c)
   );

   seg_limit_chk #(
      .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .GRAN_SHIFT(GRAN_SHIFT)
   ) u_limit (
      .limit(desc_limit), .gran(desc_gran), .offset(offset), .over(over_c)
   );

   seg_rights_chk #(.PL_W(PL_W)) u_rights (
      .is_code(desc_code), .rw(desc_rw), .dpl(desc_dpl), .cpl(cur_pl),
      .rpl(seg_value[PL_W-1:0]), .kind(acc_kind_e'(acc_kind)),
      .type_flt(type_c), .priv_flt(priv_c)
   );

   // Priority: limit, then type/access, then privilege
   always_comb begin
      if (!prot_mode)  code_c = FLT_NONE;
      else if (over_c) code_c = FLT_LIMIT;
      else if (type_c) code_c = FLT_TYPE;
      else if (priv_c) code_c = FLT_PRIV;
      else             code_c = FLT_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_addr   <= '0;
         addr_ok    <= 1'b0;
         fault      <= 1'b0;
         fault_code <= FLT_NONE;
      end else begin
         addr_ok    <= 1'b0;
         fault      <= 1'b0;
         fault_code <= FLT_NONE;
         if (req_vld) begin
            lin_addr   <= lin_c;
            addr_ok    <= (code_c == FLT_NONE);
            fault      <= (code_c != FLT_NONE);
            fault_code <= code_c;
         end
      end
   end

   // R9: valid and fault never together
   a_r9_ok_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_ok && fault));

   // R9: reason code nonzero exactly when faulting
   a_r9_code_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
      fault == (fault_code != 2'd0));

   // R9: no request means quiet flags next cycle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!addr_ok && !fault));

   // R1: segment-scaled mode never faults and adds segment*16
   a_r1_real_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !prot_mode) |=>
         (addr_ok && lin_addr == $past((ADDR_W'(seg_value) * ADDR_W'(16)) + offset)));

   // R2: descriptor mode address is base plus offset
   a_r2_prot_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && prot_mode) |=> lin_addr == $past(desc_base + offset));

   // R3: byte-granular offset beyond limit reports a limit fault
   a_r3_byte_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && prot_mode && !desc_gran && offset > ADDR_W'(desc_limit)) |=>
         (fault && fault_code == 2'd1));
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/100ps
module seg_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic        prot_mode = 1'b0;
   logic [15:0] seg_value = '0;
   logic [31:0] desc_base = '0;
   logic [19:0] desc_limit = '0;
   logic        desc_gran = 1'b0;
   logic        desc_code = 1'b0;
   logic        desc_rw = 1'b0;
   logic [1:0]  desc_dpl = '0;
   logic [31:0] offset = '0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  cur_pl = '0;
   logic [31:0] lin_addr;
   logic        addr_ok;
   logic        fault;
   logic [1:0]  fault_code;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   seg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .prot_mode(prot_mode),
      .seg_value(seg_value), .desc_base(desc_base), .desc_limit(desc_limit),
      .desc_gran(desc_gran), .desc_code(desc_code), .desc_rw(desc_rw),
      .desc_dpl(desc_dpl), .offset(offset), .acc_kind(acc_kind),
      .cur_pl(cur_pl), .lin_addr(lin_addr), .addr_ok(addr_ok),
      .fault(fault), .fault_code(fault_code)
   );

   // Reference model computed from the requirements
   task automatic model(output logic [31:0] ea, output logic [1:0] ec);
      logic [31:0] lim;
      logic [1:0]  pl;
      logic        bad_type;
      if (!prot_mode) begin
         ea = {12'h0, seg_value, 4'h0} + offset;
         ec = 2'd0;
      end else begin
         ea  = desc_base + offset;
         lim = desc_gran ? ({12'h0, desc_limit} * 32'd4096 + 32'd4095)
                         : {12'h0, desc_limit};
         pl  = (cur_pl >= seg_value[1:0]) ? cur_pl : seg_value[1:0];
         case (acc_kind)
            2'd0:    bad_type = (desc_code == 1'b0);
            2'd1:    bad_type = desc_code & ~desc_rw;
            2'd2:    bad_type = desc_code | ~desc_rw;
            default: bad_type = 1'b1;
         endcase
         if (offset > lim)  ec = 2'd1;
         else if (bad_type) ec = 2'd2;
         else if (!desc_code && acc_kind != 2'd0 && pl > desc_dpl) ec = 2'd3;
         else ec = 2'd0;
      end
   endtask

   task automatic run(input string tag);
      logic [31:0] ea;
      logic [1:0]  ec;
      model(ea, ec);
      req_vld = 1'b1;
      @(posedge clk);
      #1;
      req_vld = 1'b0;
      checks++;
      if (lin_addr !== ea || fault_code !== ec || fault !== (ec != 2'd0) ||
          addr_ok !== (ec == 2'd0)) begin
         fails++;
         $display("FAIL %s: addr=%h code=%0d ok=%b flt=%b expected addr=%h code=%0d",
                  tag, lin_addr, fault_code, addr_ok, fault, ea, ec);
      end
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin : watchdog
      #750000;
      fails++;
      $display("FAIL R9: watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin : stim
      logic [31:0] segs [5];
      logic [31:0] ofss [5];
      logic [19:0] lims [4];
      logic [31:0] eff;
      segs = '{32'h0, 32'h1, 32'h1234, 32'h8000, 32'hFFFF};
      ofss = '{32'h0, 32'h10, 32'hFFFF, 32'hFFFFFFF0, 32'hFFFFFFFF};
      lims = '{20'h0, 20'h1, 20'hFFF, 20'hFFFFF};

      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (lin_addr !== 32'h0 || addr_ok !== 1'b0 || fault !== 1'b0 || fault_code !== 2'd0) begin
         fails++;
         $display("FAIL R9: reset state addr=%h ok=%b flt=%b code=%0d expected all zero",
                  lin_addr, addr_ok, fault, fault_code);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: scaled-segment mode sweep, including wrap
      prot_mode = 1'b0;
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++) begin
            seg_value = segs[i][15:0];
            offset    = ofss[j];
            run("R1");
         end

      // R2: base plus offset, wrap at 32 bits
      prot_mode = 1'b1; desc_code = 1'b0; desc_rw = 1'b1; desc_dpl = 2'd3;
      cur_pl = 2'd0; seg_value = 16'h0010; acc_kind = 2'd1;
      desc_gran = 1'b1; desc_limit = 20'hFFFFF;
      desc_base = 32'h1000;     offset = 32'h1000; run("R2");
      desc_base = 32'hFFFFFFF0; offset = 32'h10;   run("R2");
      desc_base = 32'hFFFFFFFF; offset = 32'hFFFFFFFF; run("R2");

      // R3/R4: limit boundaries for both granularities
      desc_base = 32'h0040_0000;
      for (int g = 0; g < 2; g++)
         for (int l = 0; l < 4; l++) begin
            desc_gran  = g[0];
            desc_limit = lims[l];
            eff = g[0] ? ({12'h0, lims[l]} * 32'd4096 + 32'd4095) : {12'h0, lims[l]};
            offset = eff;          run(g[0] ? "R4" : "R3");
            offset = eff + 32'd1;  run(g[0] ? "R4" : "R3");
            offset = 32'h0;        run(g[0] ? "R4" : "R3");
            offset = 32'hFFFFFFFF; run(g[0] ? "R4" : "R3");
         end

      // R5/R6/R7/R8: full rights sweep, inside and beyond the limit
      desc_gran = 1'b0; desc_limit = 20'h0FFFF; desc_base = 32'h2000;
      for (int o = 0; o < 2; o++)
         for (int c = 0; c < 2; c++)
            for (int w = 0; w < 2; w++)
               for (int d = 0; d < 4; d++)
                  for (int p = 0; p < 4; p++)
                     for (int r = 0; r < 4; r++)
                        for (int k = 0; k < 4; k++) begin
                           offset     = o[0] ? 32'h10000 : 32'h100;
                           desc_code  = c[0];
                           desc_rw    = w[0];
                           desc_dpl   = d[1:0];
                           cur_pl     = p[1:0];
                           seg_value  = {14'h0, r[1:0]};
                           acc_kind   = k[1:0];
                           if (o[0])          run("R8");
                           else if (k == 0)   run("R5");
                           else if (c[0] || k == 3) run("R6");
                           else               run("R7");
                        end

      // R9: idle cycle leaves flags low
      req_vld = 1'b0;
      @(posedge clk);
      #1;
      checks++;
      if (addr_ok !== 1'b0 || fault !== 1'b0) begin
         fails++;
         $display("FAIL R9: idle ok=%b flt=%b expected ok=0 flt=0", addr_ok, fault);
      end

      summary();
      $finish;
   end
endmodule